// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the configuration and data registers for a small group of general-purpose I/O pins and drives the pad-side controls from them. Each pin owns two 32-bit words on a simple single-cycle register bus. The control word selects the pin function (plain GPIO or one of a few alternate functions), the bias (none, pull-down, bus-keeper, pull-up), the drive strength in milliamps, and the direction. The data word holds the value driven onto the pad and a synchronized copy of what the pad currently reads.

Software writes bias and drive strength in logical units: a bias request code and a drive strength in milliamps. The bank converts these to the pad codes. A control write that asks for something the pin cannot do is dropped as a whole and flagged for one cycle. A build option removes the bus-keeper. In that variant the pull-up is sent to the pad as code 2 and a keeper request is refused. Because a data write never touches the direction, software can preload the output level while the pin is still an input and then turn the driver on, so the pad never shows a wrong level.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, every pin is an input with no pull, drive code 0 (2 mA), function 0 and output data 0, and `wr_err` is low.
- R2: Pin p has its control word at address 2p and its data word at address 2p+1. In the control word, bit 0 is the direction, bits 3:2 are the bias request, bits 8:4 are the drive strength in mA, and bits 13:12 are the function. Every other bit reads as zero.
- R3: With the keeper present, bias request 0/1/2/3 (none/pull-down/keeper/pull-up) appears unchanged on the pin's `pad_pull` field and reads back unchanged.
- R4: With the keeper removed (`KEEPER_EN`=0), a pull-up request (3) drives `pad_pull` code 2 and reads back as 3. A keeper request (2) is rejected. `pad_pull` never shows code 3.
- R5: A drive request of an even value from 2 to 16 mA sets `pad_drive` to mA/2-1, and the control word reads back the same mA value.
- R6: A control write with an odd drive value, a value below 2 or above 16, or a function value of `NUM_FUNCS` or more leaves the whole control word unchanged. `wr_err` is then high for exactly the cycle after the write.
- R7: `pad_oe` follows control bit 0: 1 makes the pin an output, 0 makes it an input.
- R8: Data-word bit 0 sets `pad_out` and never changes `pad_oe`. A control write never changes `pad_out`. A level written while the pin is an input is the one driven when the output is enabled.
- R9: `pad_in` is readable at data-word bit 1 after two rising clock edges. Writes to that bit are ignored.
- R10: The pin's `pad_mux` field equals the function field of its control word. Value 0 is plain GPIO.
- R11: Pad outputs change only at a clock edge where an accepted write was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Word address (2·pin + word select) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| wr_err | output | 1 | Pulses the cycle after a rejected control write |
| pad_in | input | 4 | Raw pad input levels |
| pad_out | output | 4 | Output data per pin |
| pad_oe | output | 4 | Output enable per pin |
| pad_pull | output | 8 | 2-bit bias code per pin |
| pad_drive | output | 12 | 3-bit drive code per pin |
| pad_mux | output | 8 | 2-bit function select per pin |

## Verification
Bias requests are applied with both the keeper-present and keeper-removed builds on the same bus, so the same request shows where the code remapping and the keeper rejection differ. Every even drive value from 2 to 16 mA is applied, which separates a correct mA-to-code conversion from an off-by-one. Odd, zero, too-large and out-of-range function values are applied on top of a known configuration, which shows whether a rejected write left the word untouched. Data and control writes are interleaved, and the input is toggled, to check that direction and output level are independent and that the input reaches the data word after exactly two edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        BIAS_NONE = 2'd0,
        BIAS_DOWN = 2'd1,
        BIAS_KEEP = 2'd2,
        BIAS_UP   = 2'd3
    } bias_req_e;

    localparam int OE_BIT     = 0;
    localparam int BIAS_LSB   = 2;
    localparam int DRV_LSB    = 4;
    localparam int DRV_MA_W   = 5;
    localparam int DRV_CODE_W = 3;
    localparam int IO_OUT_BIT = 0;
    localparam int IO_IN_BIT  = 1;

    typedef struct packed {
        logic                  oe;
        logic [1:0]            pull;
        logic [DRV_CODE_W-1:0] drv;
    } pin_cfg_t;

    function automatic logic ma_ok(input logic [DRV_MA_W-1:0] ma);
        return (ma >= 5'd2) && (ma <= 5'd16) && !ma[0];
    endfunction

    function automatic logic [DRV_CODE_W-1:0] ma_to_code(input logic [DRV_MA_W-1:0] ma);
        logic [DRV_MA_W-1:0] t;
        t = (ma >> 1) - 5'd1;
        return t[DRV_CODE_W-1:0];
    endfunction

    function automatic logic [DRV_MA_W-1:0] code_to_ma(input logic [DRV_CODE_W-1:0] c);
        return {1'b0, c, 1'b0} + 5'd2;
    endfunction

    function automatic logic [1:0] bias_to_pad(input bias_req_e r, input bit keep);
        if (!keep && r == BIAS_UP) return 2'd2;
        return r;
    endfunction

    function automatic logic [1:0] pad_to_bias(input logic [1:0] c, input bit keep);
        if (!keep && c == 2'd2) return 2'd3;
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            synced <= '0;
        end else begin
            meta   <= raw;
            synced <= meta;
        end
    end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_FUNCS = 3,
    parameter int FUNC_W    = 2,
    parameter int FUNC_LSB  = 12,
    parameter bit KEEPER_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              io_we,
    input  logic [DATA_W-1:0] wdata,
    output pin_cfg_t          cfg,
    output logic [FUNC_W-1:0] func,
    output logic              out_q,
    output logic              reject,
    output logic [DATA_W-1:0] ctrl_rd
);
    bias_req_e             req_bias;
    logic [DRV_MA_W-1:0]   req_ma;
    logic [FUNC_W-1:0]     req_func;
    logic                  func_ok;
    logic                  keep_ok;
    logic                  accept;

    always_comb begin
        req_bias = bias_req_e'(wdata[BIAS_LSB +: 2]);
        req_ma   = wdata[DRV_LSB +: DRV_MA_W];
        req_func = wdata[FUNC_LSB +: FUNC_W];
        func_ok  = int'(req_func) < NUM_FUNCS;
        keep_ok  = KEEPER_EN || (req_bias != BIAS_KEEP);
        accept   = ma_ok(req_ma) && func_ok && keep_ok;
        reject   = ctrl_we && !accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            func  <= '0;
            out_q <= 1'b0;
        end else begin
            if (ctrl_we && accept) begin
                cfg.oe   <= wdata[OE_BIT];
                cfg.pull <= bias_to_pad(req_bias, KEEPER_EN);
                cfg.drv  <= ma_to_code(req_ma);
                func     <= req_func;
            end
            if (io_we) out_q <= wdata[IO_OUT_BIT];
        end
    end

    always_comb begin
        ctrl_rd                        = '0;
        ctrl_rd[OE_BIT]                = cfg.oe;
        ctrl_rd[BIAS_LSB +: 2]         = pad_to_bias(cfg.pull, KEEPER_EN);
        ctrl_rd[DRV_LSB +: DRV_MA_W]   = code_to_ma(cfg.drv);
        ctrl_rd[FUNC_LSB +: FUNC_W]    = func;
    end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 4,
    parameter int NUM_FUNCS = 3,
    parameter int FUNC_LSB  = 12,
    parameter int DATA_W    = 32,
    parameter bit KEEPER_EN = 1'b1,
    localparam int FUNC_W   = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
    localparam int AW       = $clog2(2 * NUM_PINS),
    localparam int PW       = AW - 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic                           wr_err,
    input  logic [NUM_PINS-1:0]            pad_in,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [2*NUM_PINS-1:0]          pad_pull,
    output logic [DRV_CODE_W*NUM_PINS-1:0] pad_drive,
    output logic [FUNC_W*NUM_PINS-1:0]     pad_mux
);
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] rej;
    logic [DATA_W-1:0]   ctrl_rd [NUM_PINS];
    logic [PW-1:0]       sel_pin;

    assign sel_pin = addr[AW-1:1];

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (in_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_cfg_t          cfg;
        logic [FUNC_W-1:0] func;
        logic              out_q;
        logic              hit;

        assign hit = wr_en && (sel_pin == PW'(p));

        gpio_pin_regs #(
            .DATA_W    (DATA_W),
            .NUM_FUNCS (NUM_FUNCS),
            .FUNC_W    (FUNC_W),
            .FUNC_LSB  (FUNC_LSB),
            .KEEPER_EN (KEEPER_EN)
        ) u_regs (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (hit && !addr[0]),
            .io_we   (hit && addr[0]),
            .wdata   (wdata),
            .cfg     (cfg),
            .func    (func),
            .out_q   (out_q),
            .reject  (rej[p]),
            .ctrl_rd (ctrl_rd[p])
        );

        assign pad_oe[p]                        = cfg.oe;
        assign pad_out[p]                       = out_q;
        assign pad_pull[2*p +: 2]               = cfg.pull;
        assign pad_drive[DRV_CODE_W*p +: DRV_CODE_W] = cfg.drv;
        assign pad_mux[FUNC_W*p +: FUNC_W]      = func;
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sel_pin == PW'(p)) begin
                if (addr[0]) begin
                    rdata[IO_OUT_BIT] = pad_out[p];
                    rdata[IO_IN_BIT]  = in_sync[p];
                end else begin
                    rdata = ctrl_rd[p];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= |rej;
    end
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int NUM_PINS = 4,
    parameter int AW       = 3,
    parameter int DRV_BITS = 12,
    parameter int MUX_BITS = 8,
    parameter bit KEEPER_EN = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [AW-1:0]         addr,
    input logic                  wr_err,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [2*NUM_PINS-1:0] pad_pull,
    input logic [DRV_BITS-1:0]   pad_drive,
    input logic [MUX_BITS-1:0]   pad_mux
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_out == '0 && pad_pull == '0 &&
                 pad_drive == '0 && pad_mux == '0 && !wr_err));

    assert_err_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en) && !$past(addr[0]));

    assert_reject_keeps_cfg_R6: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $stable(pad_oe) && $stable(pad_pull) &&
                   $stable(pad_drive) && $stable(pad_mux));

    assert_io_write_keeps_oe_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[0]) |=> $stable(pad_oe));

    assert_ctrl_write_keeps_out_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr[0]) |=> $stable(pad_out));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pad_out) && $stable(pad_oe) && $stable(pad_pull) &&
                   $stable(pad_drive) && $stable(pad_mux));

    if (!KEEPER_EN) begin : g_nokeep
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
            assert_no_pullup_code3_R4: assert property (@(posedge clk) disable iff (rst)
                pad_pull[2*p +: 2] != 2'd3);
        end
    end
endmodule

bind gpio_pad_bank gpio_bank_checker #(
    .NUM_PINS  (NUM_PINS),
    .AW        (AW),
    .DRV_BITS  (gpio_bank_pkg::DRV_CODE_W * NUM_PINS),
    .MUX_BITS  (FUNC_W * NUM_PINS),
    .KEEPER_EN (KEEPER_EN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_err    (wr_err),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .pad_drive (pad_drive),
    .pad_mux   (pad_mux)
);

// File: tb/tb_gpio_pad_bank.sv
module tb_gpio_pad_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  pad_in = '0;

    logic [31:0] rdata, rdata_nk;
    logic        wr_err, wr_err_nk;
    logic [3:0]  pad_out, pad_oe, pad_out_nk, pad_oe_nk;
    logic [7:0]  pad_pull, pad_pull_nk, pad_mux, pad_mux_nk;
    logic [11:0] pad_drive, pad_drive_nk;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_pad_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wr_err(wr_err), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_drive(pad_drive), .pad_mux(pad_mux)
    );

    gpio_pad_bank #(.KEEPER_EN(1'b0)) dut_nk (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_nk), .wr_err(wr_err_nk), .pad_in(pad_in), .pad_out(pad_out_nk),
        .pad_oe(pad_oe_nk), .pad_pull(pad_pull_nk), .pad_drive(pad_drive_nk),
        .pad_mux(pad_mux_nk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // control word: oe, bias request, drive mA, function
    function automatic logic [31:0] cw(input logic oe, input logic [1:0] b,
                                       input logic [4:0] ma, input logic [1:0] f);
        return {18'd0, f, 3'd0, ma, b, 1'b0, oe};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        addr = a;
        #0.5;
    endtask

    task automatic t_reset;
        chk("R1 oe", 32'(pad_oe), 0);
        chk("R1 out", 32'(pad_out), 0);
        chk("R1 pull", 32'(pad_pull), 0);
        chk("R1 drive", 32'(pad_drive), 0);
        chk("R1 mux", 32'(pad_mux), 0);
        chk("R1 err", 32'(wr_err), 0);
        rd(3'd0);
        chk("R1 R2 ctrl readback 2mA", rdata, 32'h20);
    endtask

    task automatic t_bias;
        for (int b = 0; b < 4; b++) begin
            wr(3'd2, cw(1'b0, 2'(b), 5'd2, 2'd0));
            chk("R3 pad_pull", 32'(pad_pull[3:2]), b);
            chk("R3 err", 32'(wr_err), 0);
            rd(3'd2);
            chk("R3 readback", rdata, cw(1'b0, 2'(b), 5'd2, 2'd0));
            if (b == 2) begin
                chk("R4 keeper rejected err", 32'(wr_err_nk), 1);
                chk("R4 keeper rejected pull", 32'(pad_pull_nk[3:2]), 1);
            end else if (b == 3) begin
                chk("R4 pull-up code", 32'(pad_pull_nk[3:2]), 2);
                chk("R4 pull-up readback", rdata_nk, cw(1'b0, 2'd3, 5'd2, 2'd0));
            end else begin
                chk("R4 plain code", 32'(pad_pull_nk[3:2]), b);
            end
        end
    endtask

    task automatic t_drive;
        for (int ma = 2; ma <= 16; ma += 2) begin
            wr(3'd4, cw(1'b0, 2'd0, 5'(ma), 2'd0));
            chk("R5 pad_drive", 32'(pad_drive[8:6]), ma / 2 - 1);
            rd(3'd4);
            chk("R5 readback mA", 32'(rdata[8:4]), ma);
        end
    endtask

    task automatic t_reject;
        logic [31:0] good;
        logic [31:0] bad [4];
        good = cw(1'b1, 2'd1, 5'd8, 2'd2);
        bad[0] = cw(1'b0, 2'd3, 5'd7, 2'd0);
        bad[1] = cw(1'b0, 2'd3, 5'd0, 2'd0);
        bad[2] = cw(1'b0, 2'd3, 5'd18, 2'd0);
        bad[3] = cw(1'b0, 2'd3, 5'd4, 2'd3);
        wr(3'd4, good);
        chk("R6 good accepted", 32'(wr_err), 0);
        for (int i = 0; i < 4; i++) begin
            wr(3'd4, bad[i]);
            chk("R6 err pulse", 32'(wr_err), 1);
            rd(3'd4);
            chk("R6 word unchanged", rdata, good);
            chk("R6 pads unchanged", {pad_oe[2], pad_pull[5:4], pad_drive[8:6], pad_mux[5:4]},
                {1'b1, 2'd1, 3'd3, 2'd2});
            @(negedge clk);
            chk("R6 err one cycle", 32'(wr_err), 0);
        end
    endtask

    task automatic t_io;
        wr(3'd7, 32'h1);
        chk("R8 preload out", 32'(pad_out[3]), 1);
        chk("R8 still input R7", 32'(pad_oe[3]), 0);
        wr(3'd6, cw(1'b1, 2'd0, 5'd2, 2'd0));
        chk("R7 oe set", 32'(pad_oe[3]), 1);
        chk("R8 ctrl write keeps out", 32'(pad_out[3]), 1);
        wr(3'd7, 32'h0);
        chk("R8 io write keeps oe", 32'(pad_oe[3]), 1);
        chk("R8 out cleared", 32'(pad_out[3]), 0);
        wr(3'd6, cw(1'b0, 2'd0, 5'd2, 2'd0));
        chk("R7 oe cleared", 32'(pad_oe[3]), 0);
        chk("R8 out kept", 32'(pad_out[3]), 0);
        repeat (3) @(negedge clk);
        chk("R11 idle stable", {28'd0, pad_oe}, 32'h4);
    endtask

    task automatic t_sync;
        @(negedge clk);
        pad_in[0] = 1'b1;
        @(negedge clk);
        rd(3'd1);
        chk("R9 one edge not yet", 32'(rdata[1]), 0);
        @(negedge clk);
        rd(3'd1);
        chk("R9 two edges visible", 32'(rdata[1]), 1);
        wr(3'd1, 32'h0);
        rd(3'd1);
        chk("R9 write to in bit ignored", rdata, 32'h2);
        pad_in[0] = 1'b0;
        wr(3'd1, 32'h3);
        @(negedge clk);
        rd(3'd1);
        chk("R9 in low, out set", rdata, 32'h1);
    endtask

    task automatic t_mux;
        wr(3'd0, cw(1'b0, 2'd0, 5'd2, 2'd1));
        chk("R10 mux func1", 32'(pad_mux[1:0]), 1);
        wr(3'd0, cw(1'b0, 2'd0, 5'd2, 2'd2));
        chk("R10 mux func2", 32'(pad_mux[1:0]), 2);
        rd(3'd0);
        chk("R10 R2 func readback", rdata, 32'h2020);
        wr(3'd0, cw(1'b0, 2'd0, 5'd2, 2'd0));
        chk("R10 back to gpio", 32'(pad_mux[1:0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bias();
        t_drive();
        t_reject();
        t_io();
        t_sync();
        t_mux();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule